// File: doc/BRIEF.md
# Fetch and Decode Next-PC Controller

This block owns the instruction fetch address of a scalar five-stage pipeline whose instruction set has an architectural branch delay slot. Each cycle it presents a fetch address to a one-cycle-latency instruction memory and assumes the next instruction is the sequential one. Conditional branches, direct jumps and jumps through a register are resolved while the fetched word sits in decode. A redirect takes effect in the cycle after decode, so the word already being fetched (the delay slot) always goes on to execute.

The block also enforces decode-stage stalls by freezing its fetch and decode registers and lowering the memory read enable. It carries each decoded instruction's address and a delay-slot flag down to the writeback stage. When writeback raises an exception, the handler address replaces every other fetch source and the younger in-flight work is discarded. The exception location it reports is the branch address when the excepting instruction sits in a delay slot, and the instruction's own address otherwise.

Top module: `npc_ctrl`

## Requirements
- R1: While reset is asserted, fetch_pc equals RESET_VEC (default 0), dec_valid is 0 and wb_valid is 0.
- R2: In a cycle with no stall, no exception and no taken redirect, fetch_pc advances by 4 at the next clock edge.
- R3: Opcode instr[31:26]=6'h04 branches when rs_val equals rt_val, and opcode 6'h05 branches when they differ. The comparison covers all 32 bits. The target is dec_pc + 4 + (sign-extended instr[15:0] shifted left by 2), and it becomes fetch_pc at the next edge. A branch that is not taken continues with the sequential step.
- R4: Opcode 6'h02 always jumps to {(dec_pc+4)[31:28], instr[25:0], 2'b00} at the next edge.
- R5: Opcode 6'h00 with instr[5:0]=6'h08 jumps to the value on rs_val (the register named by instr[25:21]) at the next edge.
- R6: When nothing stalls and no exception occurs, the next cycle has dec_valid=1 and dec_pc equal to the previous fetch_pc. As a result, the word after any branch or jump (its delay slot) reaches decode and is executed.
- R7: A stall without an exception lowers fetch_en in the same cycle. It holds fetch_pc, dec_pc and dec_valid, and it suppresses any redirect of the instruction held in decode.
- R8: An exception overrides stall and redirect. At the next edge fetch_pc becomes exc_handler, and dec_valid and wb_valid become 0.
- R9: An instruction that leaves decode unstalled at edge t is reported at writeback with wb_valid=1 after three further edges. A stall sends a bubble instead. restart_pc is that instruction's address, or that address minus 4 if it followed a branch or jump in decode.
- R10: When dec_valid is 0, the word on instr causes no redirect: fetch_pc steps by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr | input | 32 | Instruction word currently in decode (memory output) |
| rs_val | input | 32 | Register value named by instr[25:21] |
| rt_val | input | 32 | Register value named by instr[20:16] |
| stall | input | 1 | Issue-logic stall request for fetch and decode |
| exc | input | 1 | Exception raised by the writeback stage |
| exc_handler | input | 32 | Handler address loaded on exception |
| fetch_pc | output | 32 | Instruction fetch address |
| fetch_en | output | 1 | Memory read enable; low freezes the memory output register |
| dec_pc | output | 32 | Address of the instruction in decode |
| dec_valid | output | 1 | Decode holds a live instruction |
| wb_valid | output | 1 | Writeback holds a live instruction |
| restart_pc | output | 32 | Exception location for the writeback instruction |

## Verification
The checks assume that exc is raised only while wb_valid is high. They also assume that instr is the memory word at dec_pc, held there by fetch_en, and that rs_val and rt_val follow the register fields of instr. The bench meets these by modelling the memory as a register loaded only under fetch_en and the register file as a fixed table indexed by the fields of instr. It raises exc only when its own model shows a live writeback instruction. Stalls and exceptions are drawn from a seeded pseudo-random stream, so they land on branches, delay slots and bubbles alike.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam logic [5:0] OPC_REGOP = 6'h00;
  localparam logic [5:0] OPC_JUMP  = 6'h02;
  localparam logic [5:0] OPC_BREQ  = 6'h04;
  localparam logic [5:0] OPC_BRNE  = 6'h05;
  localparam logic [5:0] FN_JREG   = 6'h08;

  typedef enum logic [1:0] {
    NX_SEQ  = 2'd0,
    NX_REDIR = 2'd1,
    NX_HOLD = 2'd2,
    NX_TRAP = 2'd3
  } nx_sel_e;
endpackage

// File: rtl/npc_branch_resolve.sv
module npc_branch_resolve #(
  parameter int AW = 32,
  parameter int IW = 32
) (
  input  logic [IW-1:0] instr,
  input  logic [AW-1:0] dec_pc,
  input  logic          dec_valid,
  input  logic [AW-1:0] rs_val,
  input  logic [AW-1:0] rt_val,
  output logic          is_cti,
  output logic          take,
  output logic [AW-1:0] target
);
  import npc_pkg::*;

  localparam logic [AW-1:0] STEP = AW'(4);
  localparam int IMMW = 16;
  localparam int IDXW = 26;

  logic [5:0]      opc;
  logic [5:0]      fn;
  logic [AW-1:0]   pc_next;
  logic [AW-1:0]   br_off;
  logic            regs_eq;

  assign opc     = instr[IW-1 -: 6];
  assign fn      = instr[5:0];
  assign pc_next = dec_pc + STEP;
  assign br_off  = {{(AW-IMMW-2){instr[IMMW-1]}}, instr[IMMW-1:0], 2'b00};
  assign regs_eq = (rs_val == rt_val);

  always_comb begin
    is_cti = 1'b0;
    take   = 1'b0;
    target = pc_next;
    unique case (opc)
      OPC_BREQ: begin
        is_cti = 1'b1;
        take   = regs_eq;
        target = pc_next + br_off;
      end
      OPC_BRNE: begin
        is_cti = 1'b1;
        take   = !regs_eq;
        target = pc_next + br_off;
      end
      OPC_JUMP: begin
        is_cti = 1'b1;
        take   = 1'b1;
        target = {pc_next[AW-1:IDXW+2], instr[IDXW-1:0], 2'b00};
      end
      OPC_REGOP: begin
        if (fn == FN_JREG) begin
          is_cti = 1'b1;
          take   = 1'b1;
          target = rs_val;
        end
      end
      default: ;
    endcase
    if (!dec_valid) begin
      is_cti = 1'b0;
      take   = 1'b0;
    end
  end
endmodule

// File: rtl/npc_pc_regs.sv
module npc_pc_regs #(
  parameter int              AW        = 32,
  parameter logic [AW-1:0]   RESET_VEC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  npc_pkg::nx_sel_e sel,
  input  logic [AW-1:0]   redir_pc,
  input  logic [AW-1:0]   trap_pc,
  input  logic            dec_is_cti,
  output logic [AW-1:0]   fpc_q,
  output logic [AW-1:0]   dpc_q,
  output logic            dvld_q,
  output logic            dslot_q
);
  import npc_pkg::*;

  localparam logic [AW-1:0] STEP = AW'(4);

  logic [AW-1:0] fpc_d;
  logic [AW-1:0] dpc_d;
  logic          dvld_d;
  logic          dslot_d;

  always_comb begin
    fpc_d   = fpc_q;
    dpc_d   = dpc_q;
    dvld_d  = dvld_q;
    dslot_d = dslot_q;
    unique case (sel)
      NX_TRAP: begin
        fpc_d   = trap_pc;
        dvld_d  = 1'b0;
        dslot_d = 1'b0;
      end
      NX_HOLD: ;
      NX_REDIR: begin
        fpc_d   = redir_pc;
        dpc_d   = fpc_q;
        dvld_d  = 1'b1;
        dslot_d = dec_is_cti;
      end
      default: begin
        fpc_d   = fpc_q + STEP;
        dpc_d   = fpc_q;
        dvld_d  = 1'b1;
        dslot_d = dec_is_cti;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fpc_q   <= RESET_VEC;
      dpc_q   <= RESET_VEC;
      dvld_q  <= 1'b0;
      dslot_q <= 1'b0;
    end else begin
      fpc_q   <= fpc_d;
      dpc_q   <= dpc_d;
      dvld_q  <= dvld_d;
      dslot_q <= dslot_d;
    end
  end
endmodule

// File: rtl/npc_restart_track.sv
module npc_restart_track #(
  parameter int AW    = 32,
  parameter int DEPTH = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          in_v,
  input  logic [AW-1:0] in_pc,
  input  logic          in_slot,
  output logic          out_v,
  output logic [AW-1:0] out_pc,
  output logic          out_slot
);
  logic [DEPTH-1:0] v_q;
  logic [DEPTH-1:0] s_q;
  logic [AW-1:0]    pc_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic          src_v;
    logic          src_s;
    logic [AW-1:0] src_pc;
    logic          v_d;
    logic          s_d;
    logic [AW-1:0] pc_d;

    if (i == 0) begin : g_head
      assign src_v  = in_v;
      assign src_s  = in_slot;
      assign src_pc = in_pc;
    end else begin : g_body
      assign src_v  = v_q[i-1];
      assign src_s  = s_q[i-1];
      assign src_pc = pc_q[i-1];
    end

    always_comb begin
      v_d  = src_v && !flush;
      s_d  = src_s && !flush;
      pc_d = src_pc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q[i]  <= 1'b0;
        s_q[i]  <= 1'b0;
        pc_q[i] <= '0;
      end else begin
        v_q[i]  <= v_d;
        s_q[i]  <= s_d;
        pc_q[i] <= pc_d;
      end
    end
  end

  assign out_v    = v_q[DEPTH-1];
  assign out_slot = s_q[DEPTH-1];
  assign out_pc   = pc_q[DEPTH-1];
endmodule

// File: rtl/npc_ctrl.sv
module npc_ctrl #(
  parameter int            AW        = 32,
  parameter int            IW        = 32,
  parameter int            WB_DIST   = 3,
  parameter logic [AW-1:0] RESET_VEC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] instr,
  input  logic [AW-1:0] rs_val,
  input  logic [AW-1:0] rt_val,
  input  logic          stall,
  input  logic          exc,
  input  logic [AW-1:0] exc_handler,
  output logic [AW-1:0] fetch_pc,
  output logic          fetch_en,
  output logic [AW-1:0] dec_pc,
  output logic          dec_valid,
  output logic          wb_valid,
  output logic [AW-1:0] restart_pc
);
  import npc_pkg::*;

  localparam logic [AW-1:0] STEP = AW'(4);

  logic          is_cti;
  logic          take;
  logic [AW-1:0] target;
  logic          dslot;
  logic          adv;
  logic [AW-1:0] wb_pc;
  logic          wb_slot;
  nx_sel_e       sel;

  npc_branch_resolve #(.AW(AW), .IW(IW)) i_resolve (
    .instr     (instr),
    .dec_pc    (dec_pc),
    .dec_valid (dec_valid),
    .rs_val    (rs_val),
    .rt_val    (rt_val),
    .is_cti    (is_cti),
    .take      (take),
    .target    (target)
  );

  always_comb begin
    if (exc)        sel = NX_TRAP;
    else if (stall) sel = NX_HOLD;
    else if (take)  sel = NX_REDIR;
    else            sel = NX_SEQ;
  end

  npc_pc_regs #(.AW(AW), .RESET_VEC(RESET_VEC)) i_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel        (sel),
    .redir_pc   (target),
    .trap_pc    (exc_handler),
    .dec_is_cti (is_cti),
    .fpc_q      (fetch_pc),
    .dpc_q      (dec_pc),
    .dvld_q     (dec_valid),
    .dslot_q    (dslot)
  );

  assign adv      = dec_valid && !stall && !exc;
  assign fetch_en = !stall || exc;

  npc_restart_track #(.AW(AW), .DEPTH(WB_DIST)) i_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (exc),
    .in_v     (adv),
    .in_pc    (dec_pc),
    .in_slot  (dslot),
    .out_v    (wb_valid),
    .out_pc   (wb_pc),
    .out_slot (wb_slot)
  );

  assign restart_pc = wb_slot ? (wb_pc - STEP) : wb_pc;
endmodule

// File: rtl/npc_ctrl_chk.sv
module npc_ctrl_chk #(
  parameter int AW = 32,
  parameter int IW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [IW-1:0] instr,
  input logic [AW-1:0] rs_val,
  input logic          stall,
  input logic          exc,
  input logic [AW-1:0] exc_handler,
  input logic [AW-1:0] fetch_pc,
  input logic          fetch_en,
  input logic [AW-1:0] dec_pc,
  input logic          dec_valid,
  input logic          wb_valid
);
  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !exc) |=> (fetch_pc == $past(fetch_pc)) && (dec_pc == $past(dec_pc))
                        && (dec_valid == $past(dec_valid)));

  // R7
  stall_fetch_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !exc) |-> !fetch_en);

  // R8
  trap_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc |=> (fetch_pc == $past(exc_handler)) && !dec_valid && !wb_valid);

  // R8
  trap_from_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc |-> wb_valid);

  // R6
  decode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !exc) |=> dec_valid && (dec_pc == $past(fetch_pc)));

  // R10
  bubble_no_redir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !exc && !dec_valid) |=> (fetch_pc == $past(fetch_pc) + AW'(4)));

  // R5
  jreg_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !exc && dec_valid && instr[IW-1 -: 6] == 6'h00 && instr[5:0] == 6'h08)
      |=> (fetch_pc == $past(rs_val)));
endmodule

bind npc_ctrl npc_ctrl_chk #(.AW(AW), .IW(IW)) i_chk (.*);

// File: tb/test_npc_ctrl.sv
module test_npc_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [31:0] instr;
  logic [31:0] rs_val;
  logic [31:0] rt_val;
  logic        stall;
  logic        exc;
  logic [31:0] exc_handler;
  logic [31:0] fetch_pc;
  logic        fetch_en;
  logic [31:0] dec_pc;
  logic        dec_valid;
  logic        wb_valid;
  logic [31:0] restart_pc;

  npc_ctrl i_npc_ctrl (
    .clk(clk), .rst_n(rst_n), .instr(instr), .rs_val(rs_val), .rt_val(rt_val),
    .stall(stall), .exc(exc), .exc_handler(exc_handler), .fetch_pc(fetch_pc),
    .fetch_en(fetch_en), .dec_pc(dec_pc), .dec_valid(dec_valid),
    .wb_valid(wb_valid), .restart_pc(restart_pc)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // environment: instruction memory with read enable, fixed register table
  logic [31:0] mem  [64];
  logic [31:0] regs [32];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) instr <= 32'h0;
    else if (fetch_en) instr <= mem[fetch_pc[7:2]];
  end
  assign rs_val = regs[instr[25:21]];
  assign rt_val = regs[instr[20:16]];

  function automatic logic [31:0] enc_br(input logic [5:0] op, input int rs, input int rt, input int off);
    logic [15:0] o = 16'(off);
    return {op, 5'(rs), 5'(rt), o};
  endfunction
  function automatic logic [31:0] enc_j(input int idx);
    return {6'h02, 26'(idx)};
  endfunction
  function automatic logic [31:0] enc_jr(input int rs);
    return {6'h00, 5'(rs), 15'h0, 6'h08};
  endfunction

  // reference model state
  logic [31:0] m_fpc, m_dpc;
  bit          m_dv, m_ds;
  bit          t_v [3];
  bit          t_s [3];
  logic [31:0] t_pc [3];

  int nchk = 0;
  int nfail = 0;
  int slot_seen = 0;
  int exc_count = 0;
  bit last_exc = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  task automatic compare();
    logic [31:0] er;
    string pre;
    pre = last_exc ? "R8 " : "";
    chk(fetch_pc === m_fpc, {pre, "R2/R3/R4/R5/R10 fetch_pc"}, fetch_pc, m_fpc);
    chk(fetch_en === (!stall || exc), "R7 fetch_en", 32'(fetch_en), 32'(!stall || exc));
    chk(dec_valid === m_dv, {pre, "R6 dec_valid"}, 32'(dec_valid), 32'(m_dv));
    if (m_dv) chk(dec_pc === m_dpc, "R6 dec_pc", dec_pc, m_dpc);
    chk(wb_valid === t_v[2], {pre, "R9 wb_valid"}, 32'(wb_valid), 32'(t_v[2]));
    if (t_v[2]) begin
      er = t_s[2] ? t_pc[2] - 32'd4 : t_pc[2];
      if (t_s[2]) slot_seen++;
      chk(restart_pc === er, "R9 restart_pc", restart_pc, er);
    end
  endtask

  task automatic model_next();
    logic [31:0] ins, a, b, pc4, tgt, nf;
    bit cti, tk;
    ins = mem[m_dpc[7:2]];
    a = regs[ins[25:21]];
    b = regs[ins[20:16]];
    pc4 = m_dpc + 32'd4;
    cti = 0; tk = 0; tgt = pc4;
    if (exc) begin
      for (int i = 0; i < 3; i++) begin t_v[i] = 0; t_s[i] = 0; end
      m_fpc = exc_handler; m_dv = 0; m_ds = 0;
      return;
    end
    t_v[2] = t_v[1]; t_s[2] = t_s[1]; t_pc[2] = t_pc[1];
    t_v[1] = t_v[0]; t_s[1] = t_s[0]; t_pc[1] = t_pc[0];
    if (stall) begin
      t_v[0] = 0; t_s[0] = 0;
      return;
    end
    t_v[0] = m_dv; t_s[0] = m_ds; t_pc[0] = m_dpc;
    if (m_dv) begin
      case (ins[31:26])
        6'h04: begin cti = 1; tk = (a == b); tgt = pc4 + {{14{ins[15]}}, ins[15:0], 2'b00}; end
        6'h05: begin cti = 1; tk = (a != b); tgt = pc4 + {{14{ins[15]}}, ins[15:0], 2'b00}; end
        6'h02: begin cti = 1; tk = 1; tgt = {pc4[31:28], ins[25:0], 2'b00}; end
        6'h00: if (ins[5:0] == 6'h08) begin cti = 1; tk = 1; tgt = a; end
        default: ;
      endcase
    end
    nf = tk ? tgt : m_fpc + 32'd4;
    m_ds = cti;
    m_dpc = m_fpc;
    m_dv = 1;
    m_fpc = nf;
  endtask

  task automatic step(input bit st, input bit ex, input logic [31:0] hv);
    @(negedge clk);
    compare();
    stall = st; exc = ex; exc_handler = hv;
    last_exc = ex;
    if (ex) exc_count++;
    model_next();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nfail++;
      nchk++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    for (int i = 0; i < 32; i++) regs[i] = 32'h0;
    regs[1] = 32'h0000_0005;
    regs[2] = 32'h0000_0005;
    regs[3] = 32'h0000_0006;
    regs[4] = 32'h8000_0005;
    regs[5] = 32'h0000_0080;
    mem[2]  = enc_br(6'h04, 1, 2, 4);     // equal: taken to 0x1C
    mem[7]  = enc_br(6'h04, 1, 4, 8);     // differs only in bit 31: not taken
    mem[9]  = enc_br(6'h05, 1, 2, 2);     // equal: not taken
    mem[11] = enc_j(16);                  // to 0x40
    mem[16] = enc_jr(5);                  // to 0x80
    mem[32] = enc_br(6'h05, 1, 3, -30);   // taken back to 0x0C
    mem[49] = enc_j(0);                   // handler returns to 0

    rst_n = 1'b0; stall = 1'b0; exc = 1'b0; exc_handler = 32'h0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(fetch_pc === 32'h0, "R1 fetch_pc", fetch_pc, 32'h0);
    chk(dec_valid === 1'b0, "R1 dec_valid", 32'(dec_valid), 32'h0);
    chk(wb_valid === 1'b0, "R1 wb_valid", 32'(wb_valid), 32'h0);
    m_fpc = 32'h0; m_dpc = 32'h0; m_dv = 0; m_ds = 0;
    for (int i = 0; i < 3; i++) begin t_v[i] = 0; t_s[i] = 0; t_pc[i] = 32'h0; end
    rst_n = 1'b1;
    model_next();

    // free running: sequential, branches, jumps, delay slots
    for (int i = 0; i < 60; i++) step(0, 0, 32'h0);
    // stalls mixed in, including on branches held in decode
    for (int i = 0; i < 300; i++) step(($urandom % 4) == 0, 0, 32'h0);
    // exceptions from live writeback, with and without stall
    for (int i = 0; i < 1500; i++) begin
      bit ex;
      ex = t_v[2] && (($urandom % 6) == 0);
      step(($urandom % 4) == 0, ex, (i % 2 == 0) ? 32'h0000_00C0 : 32'h0000_0000);
    end
    step(0, 0, 32'h0);
    chk(slot_seen > 0, "R9 delay-slot restart observed", 32'(slot_seen), 32'h1);
    chk(exc_count > 0, "R8 exceptions applied", 32'(exc_count), 32'h1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule